// File: doc/BRIEF.md
# Transmit Preamble and Pad/CRC Framer

This block sits in the transmit byte path of an Ethernet MAC, between the frame source and the PHY data interface. A frame begins when the source raises `in_valid` with `in_sof`. The framer then emits a run of 0x55 preamble bytes of programmable length and one 0xD5 start-of-frame delimiter. After that it accepts the frame bytes through a ready/valid handshake and forwards each one a cycle later. When the last byte is accepted, the framer does one of three things: it ends the frame, it appends a CRC-32 frame check sequence, or it fills the frame with zero bytes up to the minimum size and then appends the check sequence.

The pad/CRC mode comes from a global setting. A per-frame override can replace it for one frame. The mode and the preamble length are captured when the frame starts and stay fixed until the frame ends. The control is a five-state machine:
- IDLE goes to PRE when a start is seen.
- PRE stays in PRE while preamble bytes remain, then goes to DATA while emitting the delimiter.
- DATA goes to IDLE on the last byte in pass mode, to PAD on a short last byte in pad mode, and to FCS otherwise.
- PAD goes to FCS after the pad byte that brings the frame to 60 bytes.
- FCS goes back to IDLE after the fourth check byte.

Top module: `txf_framer`

## Requirements
- R1: While reset is held, and afterwards until a byte with `in_sof` is offered, `out_valid` and `in_ready` stay low. Bytes offered without `in_sof` while idle produce no output.
- R2: Every frame begins with N bytes of 0x55 followed by a single 0xD5, where N is the value of `cfg_pre_len` captured at frame start (1 to 15).
- R3: A captured `cfg_pre_len` of 0 is replaced by 7 preamble bytes.
- R4: `in_ready` is high only in the data phase. Each byte accepted there (`in_valid` and `in_ready`) appears unchanged on `out_data`, with `out_valid` high, one cycle later. Idle input cycles give cycles with `out_valid` low. A byte that carries `in_sof` in the data phase is treated as ordinary data.
- R5: Mode 2'b00 (pass) sends the frame bytes exactly as supplied, with nothing appended after the last byte.
- R6: Mode 2'b01 (append CRC) appends four check bytes with no padding. The check is the IEEE 802.3 CRC-32 over the frame bytes only: reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, output inverted, sent least significant byte first. For the nine ASCII bytes "123456789" the appended bytes are 26 39 F4 CB.
- R7: Modes 2'b10 and 2'b11 (pad and CRC) append 0x00 bytes after a frame shorter than 60 bytes until it holds 60 bytes, then append the check bytes, computed over the data and the pad. A frame of 60 bytes or more is not padded.
- R8: When `pkt_ovr_en` is high at frame start, `pkt_ovr_mode` replaces `cfg_mode` for that frame only.
- R9: Changes to `cfg_mode`, `cfg_pre_len`, `pkt_ovr_en` or `pkt_ovr_mode` after frame start do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Global pad/CRC mode: 00 pass, 01 append CRC, 1x pad then CRC |
| cfg_pre_len | input | PRE_W (4) | Preamble byte count, 0 selects the default of 7 |
| pkt_ovr_en | input | 1 | Use `pkt_ovr_mode` for the frame now starting |
| pkt_ovr_mode | input | 2 | Per-frame mode, same encoding as `cfg_mode` |
| in_valid | input | 1 | Source byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Source byte is taken at this edge |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte toward the PHY |

## Verification
The hardest case to reach from the ports is a change of the configuration while a frame is already under way, because mode and length are captured in a single IDLE cycle. The bench starts a short pass-mode frame and, in a parallel thread a few cycles later, switches the global mode, the override and the preamble length. It then requires the whole output stream to match the settings captured at the start. The pad boundary is reached with frames of exactly 59, 60 and 1 bytes. The CRC bit order is pinned down by the published nine-byte check value, which does not depend on the bench's own CRC model.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam logic [7:0]  PRE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE = 8'hD5;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam int          FCS_LEN  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS
    } txf_state_e;

    // mode encoding: 00 pass, 01 append CRC, 1x pad then CRC
    function automatic logic mode_adds_crc(input logic [1:0] m);
        return m != 2'b00;
    endfunction

    function automatic logic mode_pads(input logic [1:0] m);
        return m[1];
    endfunction

    // one byte of the reflected CRC-32 update
    function automatic logic [31:0] crc_next(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/txf_crc_acc.sv
module txf_crc_acc
    import txf_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic [7:0]       din,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       fcs_byte
);

    logic [31:0] crc_q;
    logic [31:0] fcs_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (init) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_next(crc_q, din);
        end
    end

    assign fcs_w    = ~crc_q;
    assign fcs_byte = fcs_w[8*sel +: 8];

endmodule

// File: rtl/txf_len_sel.sv
module txf_len_sel #(
    parameter int PRE_W    = 4,
    parameter int PRE_DFLT = 7
) (
    input  logic [PRE_W-1:0] raw_len,
    output logic [PRE_W-1:0] eff_len
);

    localparam logic [PRE_W-1:0] DFLT = PRE_W'(PRE_DFLT);

    always_comb begin
        eff_len = (raw_len == '0) ? DFLT : raw_len;
    end

endmodule

// File: rtl/txf_framer.sv
module txf_framer
    import txf_pkg::*;
#(
    parameter int PRE_W     = 4,
    parameter int PRE_DFLT  = 7,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [PRE_W-1:0] cfg_pre_len,
    input  logic             pkt_ovr_en,
    input  logic [1:0]       pkt_ovr_mode,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data
);

    localparam int             PAD_TO  = MIN_FRAME - FCS_LEN;
    localparam int             LEN_W   = $clog2(PAD_TO + 1);
    localparam int             SEL_W   = $clog2(FCS_LEN);
    localparam logic [LEN_W-1:0] LAST_PAD = LEN_W'(PAD_TO - 1);
    localparam logic [LEN_W-1:0] LEN_SAT  = LEN_W'(PAD_TO);
    localparam logic [SEL_W-1:0] LAST_FCS = SEL_W'(FCS_LEN - 1);

    txf_state_e       st_q, st_d;
    logic [1:0]       mode_q;
    logic [PRE_W-1:0] pre_len_q;
    logic [PRE_W-1:0] pre_cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [SEL_W-1:0] fcs_idx_q;

    logic [PRE_W-1:0] pre_len_eff;
    logic [1:0]       mode_sel;
    logic             start;

    logic             crc_init, crc_en;
    logic [7:0]       crc_din;
    logic [7:0]       fcs_byte;

    logic             ov_d;
    logic [7:0]       od_d;

    txf_len_sel #(
        .PRE_W    (PRE_W),
        .PRE_DFLT (PRE_DFLT)
    ) u_len_sel (
        .raw_len (cfg_pre_len),
        .eff_len (pre_len_eff)
    );

    txf_crc_acc #(
        .SEL_W (SEL_W)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (crc_init),
        .en       (crc_en),
        .din      (crc_din),
        .sel      (fcs_idx_q),
        .fcs_byte (fcs_byte)
    );

    assign mode_sel = pkt_ovr_en ? pkt_ovr_mode : cfg_mode;
    assign start    = in_valid && in_sof;
    assign in_ready = (st_q == ST_DATA);

    // state register with its per-state counters and frame captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            mode_q    <= 2'b00;
            pre_len_q <= PRE_W'(PRE_DFLT);
            pre_cnt_q <= '0;
            len_q     <= '0;
            fcs_idx_q <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q    <= mode_sel;
                        pre_len_q <= pre_len_eff;
                        pre_cnt_q <= PRE_W'(1);
                    end
                end
                ST_PRE: begin
                    if (pre_cnt_q < pre_len_q) begin
                        pre_cnt_q <= pre_cnt_q + 1'b1;
                    end
                    len_q     <= '0;
                    fcs_idx_q <= '0;
                end
                ST_DATA: begin
                    if (in_valid && (len_q != LEN_SAT)) begin
                        len_q <= len_q + 1'b1;
                    end
                end
                ST_PAD: begin
                    len_q <= len_q + 1'b1;
                end
                ST_FCS: begin
                    fcs_idx_q <= fcs_idx_q + 1'b1;
                end
                default: begin
                    len_q <= '0;
                end
            endcase
        end
    end

    // next state and the byte to emit
    always_comb begin
        st_d     = st_q;
        ov_d     = 1'b0;
        od_d     = 8'h00;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        crc_din  = in_data;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    ov_d = 1'b1;
                    od_d = PRE_BYTE;
                    st_d = ST_PRE;
                end
            end
            ST_PRE: begin
                ov_d = 1'b1;
                if (pre_cnt_q < pre_len_q) begin
                    od_d = PRE_BYTE;
                end else begin
                    od_d     = SFD_BYTE;
                    crc_init = 1'b1;
                    st_d     = ST_DATA;
                end
            end
            ST_DATA: begin
                if (in_valid) begin
                    ov_d   = 1'b1;
                    od_d   = in_data;
                    crc_en = 1'b1;
                    if (in_eof) begin
                        if (!mode_adds_crc(mode_q)) begin
                            st_d = ST_IDLE;
                        end else if (mode_pads(mode_q) && (len_q < LAST_PAD)) begin
                            st_d = ST_PAD;
                        end else begin
                            st_d = ST_FCS;
                        end
                    end
                end
            end
            ST_PAD: begin
                ov_d    = 1'b1;
                od_d    = 8'h00;
                crc_en  = 1'b1;
                crc_din = 8'h00;
                if (len_q == LAST_PAD) begin
                    st_d = ST_FCS;
                end
            end
            ST_FCS: begin
                ov_d = 1'b1;
                od_d = fcs_byte;
                if (fcs_idx_q == LAST_FCS) begin
                    st_d = ST_IDLE;
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // registered output byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 8'h00;
        end else begin
            out_valid <= ov_d;
            out_data  <= od_d;
        end
    end

endmodule

// File: rtl/txf_framer_chk.sv
module txf_framer_chk
    import txf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input logic       in_eof,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input txf_state_e st,
    input logic [1:0] mode
);

    logic [2:0] fcs_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcs_run <= '0;
        end else begin
            fcs_run <= (st == ST_FCS) ? fcs_run + 1'b1 : 3'd0;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !(in_valid && in_sof)) |=> !out_valid);

    // R2
    pre_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE) |=> (out_valid && (out_data == PRE_BYTE || out_data == SFD_BYTE)));

    // R4
    fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (out_valid && out_data == $past(in_data)));

    // R5
    pass_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && in_valid && in_eof && mode == 2'b00) |=> (st == ST_IDLE));

    // R6
    fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCS) |-> (fcs_run < 3'd4));

    // R7
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |=> (out_valid && out_data == 8'h00));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(mode));

endmodule

bind txf_framer txf_framer_chk u_txf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .st        (st_q),
    .mode      (mode_q)
);

// File: tb/txf_framer_bench.sv
`timescale 1ns/1ps
module txf_framer_bench;

    typedef struct packed {
        logic [7:0] len;
        logic [1:0] cm;
        logic       oe;
        logic [1:0] om;
        logic [3:0] pre;
        logic       gap;
        logic [7:0] seed;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'd10, 2'd2, 1'b0, 2'd0, 4'd7,  1'b0, 8'h11},  // R7 short, padded
        '{8'd70, 2'd2, 1'b0, 2'd0, 4'd7,  1'b0, 8'h22},  // R7 long, no pad
        '{8'd60, 2'd2, 1'b0, 2'd0, 4'd7,  1'b0, 8'h33},  // R7 exactly 60
        '{8'd59, 2'd3, 1'b0, 2'd0, 4'd7,  1'b0, 8'h44},  // R7 one pad byte, mode 11
        '{8'd20, 2'd1, 1'b0, 2'd0, 4'd7,  1'b0, 8'h55},  // R6 short, no pad
        '{8'd20, 2'd0, 1'b0, 2'd0, 4'd7,  1'b0, 8'h66},  // R5 pass
        '{8'd12, 2'd0, 1'b1, 2'd2, 4'd7,  1'b0, 8'h77},  // R8 override to pad
        '{8'd12, 2'd2, 1'b1, 2'd0, 4'd7,  1'b0, 8'h88},  // R8 override to pass
        '{8'd16, 2'd1, 1'b0, 2'd0, 4'd0,  1'b0, 8'h99},  // R3 zero length
        '{8'd16, 2'd1, 1'b0, 2'd0, 4'd1,  1'b0, 8'hAA},  // R2 one byte
        '{8'd16, 2'd1, 1'b0, 2'd0, 4'd15, 1'b0, 8'hBB},  // R2 fifteen bytes
        '{8'd1,  2'd2, 1'b0, 2'd0, 4'd3,  1'b0, 8'hCC},  // R7 single byte
        '{8'd25, 2'd1, 1'b0, 2'd0, 4'd5,  1'b1, 8'hDD}   // R4 gaps
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic [3:0] cfg_pre_len;
    logic       pkt_ovr_en;
    logic [1:0] pkt_ovr_mode;
    logic       in_valid, in_sof, in_eof;
    logic [7:0] in_data;
    logic       in_ready, out_valid;
    logic [7:0] out_data;

    logic [7:0] pl [128];
    logic [7:0] got [$];
    logic [7:0] expq [$];
    int errs   = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    txf_framer u_txf_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_pre_len  (cfg_pre_len),
        .pkt_ovr_en   (pkt_ovr_en),
        .pkt_ovr_mode (pkt_ovr_mode),
        .in_valid     (in_valid),
        .in_sof       (in_sof),
        .in_eof       (in_eof),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_data     (out_data)
    );

    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) got.push_back(out_data);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic build_exp(input int n, input logic [1:0] m, input int pre);
        logic [31:0] c = 32'hFFFF_FFFF;
        int k;
        expq.delete();
        for (int i = 0; i < pre; i++) expq.push_back(8'h55);
        expq.push_back(8'hD5);
        for (int i = 0; i < n; i++) begin
            expq.push_back(pl[i]);
            c = crc_step(c, pl[i]);
        end
        if (m != 2'b00) begin
            k = n;
            if (m[1]) begin
                while (k < 60) begin
                    expq.push_back(8'h00);
                    c = crc_step(c, 8'h00);
                    k++;
                end
            end
            c = ~c;
            for (int i = 0; i < 4; i++) expq.push_back(c[8*i +: 8]);
        end
    endtask

    task automatic send(input int n, input bit gap, input int sof2);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0) || (i == sof2);
            in_eof   = (i == n - 1);
            in_data  = pl[i];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (gap) begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eof   = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic compare(input string req);
        int bad = -1;
        repeat (80) @(negedge clk);
        chk(got.size() == expq.size(), req, "stream length", got.size(), expq.size());
        for (int i = 0; i < got.size() && i < expq.size(); i++) begin
            if (bad < 0 && got[i] !== expq[i]) bad = i;
        end
        if (bad >= 0) chk(1'b0, req, $sformatf("byte %0d", bad), got[bad], expq[bad]);
        else          chk(1'b1, req, "stream bytes", 0, 0);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 3, 11: return "R7";
            4:              return "R6";
            5:              return "R5";
            6, 7:           return "R8";
            8:              return "R3";
            9, 10:          return "R2";
            default:        return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_mode = 2'b00; cfg_pre_len = 4'd7;
        pkt_ovr_en = 1'b0; pkt_ovr_mode = 2'b00;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        // R1 bytes without in_sof while idle
        in_valid = 1'b1; in_data = 8'hA5;
        repeat (6) @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(got.size() == 0, "R1", "output without start", got.size(), 0);
        chk(in_ready == 1'b0, "R1", "in_ready idle", in_ready, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0] me;
            int pe;
            cfg_mode     = VECS[v].cm;
            cfg_pre_len  = VECS[v].pre;
            pkt_ovr_en   = VECS[v].oe;
            pkt_ovr_mode = VECS[v].om;
            for (int i = 0; i < VECS[v].len; i++) pl[i] = VECS[v].seed + 8'(i * 7);
            me = VECS[v].oe ? VECS[v].om : VECS[v].cm;
            pe = (VECS[v].pre == 0) ? 7 : int'(VECS[v].pre);
            build_exp(VECS[v].len, me, pe);
            got.delete();
            send(VECS[v].len, VECS[v].gap, -1);
            compare(tag_of(v));
        end

        // R6 known check value
        pkt_ovr_en = 1'b0; cfg_mode = 2'b01; cfg_pre_len = 4'd7;
        for (int i = 0; i < 9; i++) pl[i] = 8'h31 + 8'(i);
        build_exp(9, 2'b01, 7);
        got.delete();
        send(9, 1'b0, -1);
        compare("R6");
        if (got.size() == 21) begin
            chk({got[20], got[19], got[18], got[17]} == 32'hCBF43926, "R6",
                "check value", {got[20], got[19], got[18], got[17]}, 32'hCBF43926);
        end else begin
            chk(1'b0, "R6", "check value length", got.size(), 21);
        end

        // R9 settings changed mid-frame; R4 in_sof inside frame is data
        cfg_mode = 2'b00; cfg_pre_len = 4'd7; pkt_ovr_en = 1'b0;
        for (int i = 0; i < 12; i++) pl[i] = 8'hE0 + 8'(i);
        build_exp(12, 2'b00, 7);
        got.delete();
        fork
            send(12, 1'b0, 5);
            begin
                repeat (4) @(negedge clk);
                cfg_mode = 2'b10; pkt_ovr_en = 1'b1; pkt_ovr_mode = 2'b01;
                cfg_pre_len = 4'd2;
            end
        join
        compare("R9");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule